// File: doc/BRIEF.md
# Conditional Branch and Halt Unit

This unit handles the branch/halt instruction class of a 16-bit instruction set. It decodes an instruction word, tests one of eight conditions against flags kept from the most recent integer compare, and works out the program counter for the next instruction. Fetch logic uses `next_pc_o` to choose the next address. `taken_o`, `target_o`, `halt_o` and `illegal_o` tell the surrounding pipeline what happened.

Instruction layout: bits [15:12] hold the class opcode `4'b0100`. Bits [11:9] hold the condition. Bits [8:0] hold a signed immediate. A branch moves the PC by the signed amount (imm + 1) × 4.

An immediate of zero is never a legal branch. With condition 0 that word (`16'h4000`) stops the core. With any other condition it is flagged as illegal.

A compare unit elsewhere supplies zero, signed-less, unsigned-less and overflow. Those come from subtracting the source operand from the destination. The unit registers the four flags whenever `cmp_valid_i` is high and holds them until the next compare.

Top module: `branch_halt_unit`

## Requirements
- R1: When `instr_valid_i` is high and `instr_i[15:12]` is not `4'b0100`, `taken_o` and `illegal_o` are 0 and `next_pc_o` is `pc_i + 2`.
- R2: `target_o` equals `pc_i` plus the sign-extended value (signed(`instr_i[8:0]`) + 1) × 4. Immediate 255 gives +1024, immediate 0x100 gives −1020, and immediate 0x1FF gives 0.
- R3: A class-0100 word that does not branch, and is not the halt word, gives `next_pc_o = pc_i + 2`. A taken branch gives `next_pc_o = target_o`.
- R4: Condition field [11:9] selects the test on the held flags. The values are: 0 always; 1 signed less-or-equal (slt or zero); 2 signed greater (neither slt nor zero); 3 unsigned less-or-equal (ult or zero); 4 unsigned greater (neither ult nor zero); 5 zero; 6 not zero; 7 overflow.
- R5: A class-0100 word with a zero immediate and a nonzero condition raises `illegal_o` in the same cycle. It does not branch, and `next_pc_o` is `pc_i + 2`.
- R6: The word `16'h4000` makes `next_pc_o = pc_i` in its own cycle and raises `halt_o` from the next clock edge. `halt_o` stays high until reset.
- R7: While `halt_o` is high, `next_pc_o` holds the address of the halt word, and `taken_o` and `illegal_o` stay 0 for every input.
- R8: Flags are loaded on a clock edge where `cmp_valid_i` is high. A branch in that same cycle is judged on the flags held before that edge.
- R9: While `instr_valid_i` is low, `taken_o` and `illegal_o` are 0 and `next_pc_o` equals `pc_i`.
- R10: Reset (`rst_ni` low, asynchronous) clears all four flags and the halt state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word is present this cycle |
| instr_i | input | 16 | Instruction word |
| pc_i | input | PC_W | Address of the instruction |
| cmp_valid_i | input | 1 | An integer compare completes; load flags |
| cmp_zero_i | input | 1 | Compare result is zero |
| cmp_slt_i | input | 1 | Destination less than source, signed |
| cmp_ult_i | input | 1 | Destination less than source, unsigned |
| cmp_ovf_i | input | 1 | Compare subtraction overflowed |
| taken_o | output | 1 | Branch taken |
| target_o | output | PC_W | Branch target address |
| next_pc_o | output | PC_W | Address of the next instruction |
| halt_o | output | 1 | Core halted |
| illegal_o | output | 1 | Illegal branch encoding |

## Verification
A compare can load new flags in the same cycle that a conditional branch reads them. To provoke this, the bench presents an equal-condition branch while a compare with the zero flag set is being loaded. It checks that the branch resolves on the old flags in that cycle and on the new flags once the edge has passed. A second case sends the halt word: the bench checks `next_pc_o` in the halt cycle, then keeps presenting branch and illegal words and checks that none of them have any effect at the outputs.

// File: rtl/bru_pkg.sv
package bru_pkg;
  localparam int INSTR_W = 16;
  localparam int OPC_W   = 4;
  localparam int COND_W  = 3;
  localparam int IMM_W   = 9;
  localparam logic [OPC_W-1:0] OPC_BRU = 4'b0100;

  typedef enum logic [COND_W-1:0] {
    COND_ALW = 3'd0,
    COND_LES = 3'd1,
    COND_GTS = 3'd2,
    COND_LEU = 3'd3,
    COND_GTU = 3'd4,
    COND_EQ  = 3'd5,
    COND_NE  = 3'd6,
    COND_OVF = 3'd7
  } cond_e;

  typedef struct packed {
    logic zero;
    logic slt;
    logic ult;
    logic ovf;
  } flags_t;
endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output cond_e              cond_o,
  output logic [IMM_W-1:0]   imm_o,
  output logic               branch_o,
  output logic               halt_word_o,
  output logic               illegal_o
);
  logic in_class;
  logic imm_zero;

  assign in_class    = (instr_i[INSTR_W-1 -: OPC_W] == OPC_BRU);
  assign cond_o      = cond_e'(instr_i[IMM_W +: COND_W]);
  assign imm_o       = instr_i[IMM_W-1:0];
  assign imm_zero    = (imm_o == '0);
  assign branch_o    = in_class & ~imm_zero;
  assign halt_word_o = in_class & imm_zero & (cond_o == COND_ALW);
  assign illegal_o   = in_class & imm_zero & (cond_o != COND_ALW);
endmodule

// File: rtl/bru_flags.sv
module bru_flags
  import bru_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  flags_t flags_i,
  output flags_t flags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flags_o <= '0;
    else if (load_i) flags_o <= flags_i;
  end
endmodule

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
(
  input  cond_e  cond_i,
  input  flags_t flags_i,
  output logic   pass_o
);
  logic les, leu;
  assign les = flags_i.slt | flags_i.zero;
  assign leu = flags_i.ult | flags_i.zero;

  always_comb begin
    unique case (cond_i)
      COND_ALW: pass_o = 1'b1;
      COND_LES: pass_o = les;
      COND_GTS: pass_o = ~les;
      COND_LEU: pass_o = leu;
      COND_GTU: pass_o = ~leu;
      COND_EQ:  pass_o = flags_i.zero;
      COND_NE:  pass_o = ~flags_i.zero;
      COND_OVF: pass_o = flags_i.ovf;
      default:  pass_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bru_target.sv
module bru_target
  import bru_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [PC_W-1:0]  target_o,
  output logic [PC_W-1:0]  seq_o
);
  localparam int STEP_W = IMM_W + 1;
  localparam int OFFS_W = STEP_W + 2;

  logic signed [STEP_W-1:0] step;
  logic signed [OFFS_W-1:0] offs;
  logic        [PC_W-1:0]   offs_ext;

  // imm + 1 in one extra bit so +256 does not wrap
  assign step     = $signed({imm_i[IMM_W-1], imm_i}) + STEP_W'(1);
  assign offs     = {step, 2'b00};
  assign offs_ext = {{(PC_W-OFFS_W){offs[OFFS_W-1]}}, offs};
  assign target_o = pc_i + offs_ext;
  assign seq_o    = pc_i + PC_W'(2);
endmodule

// File: rtl/branch_halt_unit.sv
module branch_halt_unit
  import bru_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 instr_valid_i,
  input  logic [INSTR_W-1:0]   instr_i,
  input  logic [PC_W-1:0]      pc_i,
  input  logic                 cmp_valid_i,
  input  logic                 cmp_zero_i,
  input  logic                 cmp_slt_i,
  input  logic                 cmp_ult_i,
  input  logic                 cmp_ovf_i,
  output logic                 taken_o,
  output logic [PC_W-1:0]      target_o,
  output logic [PC_W-1:0]      next_pc_o,
  output logic                 halt_o,
  output logic                 illegal_o
);
  cond_e            cond;
  logic [IMM_W-1:0] imm;
  logic             branch, halt_word, bad_enc, pass;
  flags_t           flags_d, flags_q;
  logic [PC_W-1:0]  target, seq;
  logic             halted_q;
  logic [PC_W-1:0]  halt_pc_q;
  logic             live, halt_hit;

  bru_decode u_dec (
    .instr_i    (instr_i),
    .cond_o     (cond),
    .imm_o      (imm),
    .branch_o   (branch),
    .halt_word_o(halt_word),
    .illegal_o  (bad_enc)
  );

  assign flags_d = '{zero: cmp_zero_i, slt: cmp_slt_i, ult: cmp_ult_i, ovf: cmp_ovf_i};

  bru_flags u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cmp_valid_i),
    .flags_i(flags_d),
    .flags_o(flags_q)
  );

  bru_cond u_cond (
    .cond_i (cond),
    .flags_i(flags_q),
    .pass_o (pass)
  );

  bru_target #(.PC_W(PC_W)) u_tgt (
    .pc_i    (pc_i),
    .imm_i   (imm),
    .target_o(target),
    .seq_o   (seq)
  );

  assign live      = instr_valid_i & ~halted_q;
  assign taken_o   = live & branch & pass;
  assign illegal_o = live & bad_enc;
  assign halt_hit  = live & halt_word;
  assign target_o  = target;
  assign halt_o    = halted_q;

  always_comb begin
    if (halted_q)           next_pc_o = halt_pc_q;
    else if (!instr_valid_i) next_pc_o = pc_i;
    else if (taken_o)       next_pc_o = target;
    else if (halt_hit)      next_pc_o = pc_i;
    else                    next_pc_o = seq;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halted_q  <= 1'b0;
      halt_pc_q <= '0;
    end else if (halt_hit) begin
      halted_q  <= 1'b1;
      halt_pc_q <= pc_i;
    end
  end
endmodule

// File: rtl/bru_checker.sv
module bru_checker
  import bru_pkg::*;
#(
  parameter int PC_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               instr_valid_i,
  input logic [INSTR_W-1:0] instr_i,
  input logic [PC_W-1:0]    pc_i,
  input logic               taken_o,
  input logic [PC_W-1:0]    target_o,
  input logic [PC_W-1:0]    next_pc_o,
  input logic               halt_o,
  input logic               illegal_o
);
  localparam logic [INSTR_W-1:0] HALT_WORD = 16'h4000;

  AST_ILLEGAL_NOT_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !taken_o) else $error("illegal taken"); // R5
  AST_TAKEN_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> next_pc_o == target_o) else $error("taken pc"); // R3
  AST_SEQ_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && !halt_o && !taken_o && instr_i != HALT_WORD) |-> next_pc_o == pc_i + PC_W'(2))
    else $error("seq pc"); // R3
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o) else $error("halt dropped"); // R6
  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> (!taken_o && !illegal_o)) else $error("halted active"); // R7
  AST_HALT_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && $past(halt_o)) |-> $stable(next_pc_o)) else $error("halt pc moved"); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |-> (!taken_o && !illegal_o)) else $error("idle active"); // R9
  AST_ALWAYS_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && !halt_o && instr_i[15:9] == 7'b0100_000 && instr_i[8:0] != '0) |-> taken_o)
    else $error("always not taken"); // R4
endmodule

bind branch_halt_unit bru_checker #(.PC_W(PC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .instr_valid_i(instr_valid_i),
  .instr_i      (instr_i),
  .pc_i         (pc_i),
  .taken_o      (taken_o),
  .target_o     (target_o),
  .next_pc_o    (next_pc_o),
  .halt_o       (halt_o),
  .illegal_o    (illegal_o)
);

// File: tb/sim_branch_halt_unit.sv
module sim_branch_halt_unit;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ivld = 1'b0;
  logic [15:0]     instr = '0;
  logic [PC_W-1:0] pc = '0;
  logic            cvld = 1'b0;
  logic            cz = 1'b0, cs = 1'b0, cu = 1'b0, co = 1'b0;
  logic            taken, halt, illegal;
  logic [PC_W-1:0] target, next_pc;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench copy of the held flags, from R8/R10
  logic fz = 1'b0, fs = 1'b0, fu = 1'b0, fo = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_halt_unit #(.PC_W(PC_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(ivld), .instr_i(instr), .pc_i(pc),
    .cmp_valid_i(cvld), .cmp_zero_i(cz), .cmp_slt_i(cs), .cmp_ult_i(cu), .cmp_ovf_i(co),
    .taken_o(taken), .target_o(target), .next_pc_o(next_pc), .halt_o(halt), .illegal_o(illegal)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic cond_ok(input int c, input logic z, input logic s, input logic u, input logic o);
    case (c)
      0: return 1'b1;
      1: return s | z;
      2: return !(s | z);
      3: return u | z;
      4: return !(u | z);
      5: return z;
      6: return !z;
      default: return o;
    endcase
  endfunction

  function automatic logic [31:0] exp_tgt(input logic [31:0] p, input logic [8:0] imm);
    int off;
    off = ($signed({{23{imm[8]}}, imm}) + 1) * 4;
    return p + 32'(off);
  endfunction

  task automatic load_flags(input logic z, input logic s, input logic u, input logic o);
    @(negedge clk);
    cvld = 1'b1; cz = z; cs = s; cu = u; co = o;
    @(posedge clk);
    fz = z; fs = s; fu = u; fo = o;
    @(negedge clk);
    cvld = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R10 halt at reset", 32'(halt), 0);
    ivld = 1'b1; instr = 16'h4A05; pc = 32'h100; #1; // cond 5 eq, zero flag cleared
    chk("R10 eq not taken after reset", 32'(taken), 0);
    instr = 16'h4C05; #1; // cond 6 ne
    chk("R10 ne taken after reset", 32'(taken), 1);
    ivld = 1'b0;
  endtask

  task automatic t_cond_sweep();
    logic [3:0] combos [6] = '{4'b0000, 4'b1000, 4'b0100, 4'b0010, 4'b0001, 4'b0110};
    for (int k = 0; k < 6; k++) begin
      load_flags(combos[k][3], combos[k][2], combos[k][1], combos[k][0]);
      for (int c = 0; c < 8; c++) begin
        logic e;
        ivld = 1'b1; pc = 32'h2000 + 32'(c * 16); instr = {4'b0100, 3'(c), 9'd5};
        #1;
        e = cond_ok(c, fz, fs, fu, fo);
        chk($sformatf("R4 cond %0d flags %b taken", c, combos[k]), 32'(taken), 32'(e));
        chk("R3 next pc", next_pc, e ? exp_tgt(pc, 9'd5) : pc + 2);
        @(negedge clk);
      end
    end
    ivld = 1'b0;
  endtask

  task automatic t_offsets();
    logic [8:0] imms [4] = '{9'd255, 9'h100, 9'h1FF, 9'd1};
    logic [31:0] offs [4] = '{32'd1024, -32'sd1020, 32'd0, 32'd8};
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ivld = 1'b1; pc = 32'h0001_0000; instr = {4'b0100, 3'd0, imms[k]};
      #1;
      chk($sformatf("R2 target imm 0x%03h", imms[k]), target, pc + offs[k]);
      chk("R2 taken next pc", next_pc, pc + offs[k]);
    end
    ivld = 1'b0;
  endtask

  task automatic t_illegal();
    for (int c = 1; c < 8; c++) begin
      @(negedge clk);
      ivld = 1'b1; pc = 32'h3000; instr = {4'b0100, 3'(c), 9'd0};
      #1;
      chk($sformatf("R5 illegal cond %0d", c), 32'(illegal), 1);
      chk("R5 illegal not taken", 32'(taken), 0);
      chk("R5 illegal next pc", next_pc, 32'h3002);
    end
    ivld = 1'b0;
  endtask

  task automatic t_other_opcode();
    logic [15:0] words [4] = '{16'h0000, 16'h5000, 16'hC005, 16'h3A00};
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ivld = 1'b1; pc = 32'h4000; instr = words[k];
      #1;
      chk("R1 other class not taken", 32'(taken), 0);
      chk("R1 other class not illegal", 32'(illegal), 0);
      chk("R1 other class next pc", next_pc, 32'h4002);
    end
    ivld = 1'b0;
  endtask

  task automatic t_invalid();
    @(negedge clk);
    ivld = 1'b0; pc = 32'h5000; instr = 16'h4005;
    #1;
    chk("R9 idle not taken", 32'(taken), 0);
    chk("R9 idle next pc", next_pc, 32'h5000);
    instr = 16'h4200; #1;
    chk("R9 idle not illegal", 32'(illegal), 0);
  endtask

  task automatic t_same_cycle();
    load_flags(1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    cvld = 1'b1; cz = 1'b1; cs = 1'b0; cu = 1'b0; co = 1'b0;
    ivld = 1'b1; pc = 32'h6000; instr = 16'h4A03; // eq
    #1;
    chk("R8 same cycle uses old flags", 32'(taken), 0);
    @(negedge clk);
    cvld = 1'b0; cz = 1'b0;
    #1;
    chk("R8 new flags after edge", 32'(taken), 1);
    chk("R8 next pc", next_pc, exp_tgt(32'h6000, 9'd3));
    @(negedge clk);
    chk("R8 flags held", 32'(taken), 1);
    ivld = 1'b0;
  endtask

  task automatic t_halt();
    @(negedge clk);
    ivld = 1'b1; pc = 32'h7000; instr = 16'h4000;
    #1;
    chk("R6 halt word next pc", next_pc, 32'h7000);
    chk("R6 halt not yet", 32'(halt), 0);
    chk("R6 halt not taken", 32'(taken), 0);
    @(negedge clk);
    pc = 32'h7100; instr = 16'h4005;
    #1;
    chk("R6 halt raised", 32'(halt), 1);
    chk("R7 halted not taken", 32'(taken), 0);
    chk("R7 halted next pc", next_pc, 32'h7000);
    @(negedge clk);
    instr = 16'h4E00; pc = 32'h7200;
    #1;
    chk("R7 halted not illegal", 32'(illegal), 0);
    chk("R6 halt sticky", 32'(halt), 1);
    chk("R7 halted pc still", next_pc, 32'h7000);
    rst_n = 1'b0;
    #1;
    chk("R10 reset clears halt", 32'(halt), 0);
    @(negedge clk);
    rst_n = 1'b1;
    instr = 16'h4005; pc = 32'h7300;
    #1;
    chk("R10 runs after reset", next_pc, exp_tgt(32'h7300, 9'd5));
    ivld = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cond_sweep();
    t_offsets();
    t_illegal();
    t_other_opcode();
    t_invalid();
    t_same_cycle();
    t_halt();
    done = 1'b1;
    summary();
  end
endmodule